// File: doc/BRIEF.md
# Configurable External Interrupt Trigger Unit

This block turns six raw interrupt request lines into six pending lines for an interrupt controller. Four lines come from external pins and two come from an on-chip logic array. Every line passes through a two-flop synchronizer. A 2-bit mode field per source then picks one of four senses: active-high level, active-low level, rising edge or falling edge.

In the level senses, the pending output tracks the synchronized input, inverted for active-low. In the edge senses, a detected edge sets a sticky flag. That flag holds until software writes a one to the source's bit in a write-only clear register. If software changes a source's mode, the flag drops, so an old edge cannot carry over into the new sense.

The write port has three targets. Mode register A holds the mode fields for four sources. Mode register B holds the mode fields for the other two. The clear register uses a sparse bit map. Priority, masking and vectoring belong to the consumer of the pending lines.

Top module: `irq_trigger_unit`

## Requirements
- R1: While reset is asserted and after it is released with all raw inputs low, every pending output is 0, and every mode field is 2'b00.
- R2: A write to address 0 loads four mode fields: bits [1:0] for source 0 (external 0), [3:2] for source 1 (external 1), [5:4] for source 2 (logic array 0) and [7:6] for source 3 (external 2). The encoding is 00 high level, 01 low level, 10 rising edge, 11 falling edge.
- R3: A write to address 1 loads the fields of source 4 (external 3) from bits [1:0] and of source 5 (logic array 1) from bits [3:2], with the same encoding as R2.
- R4: In high-level mode, pending equals the raw input two clock edges after the input changes.
- R5: In low-level mode, pending equals the inverted raw input, with the same latency as R4.
- R6: In rising-edge mode, a 0-to-1 change on the raw input sets pending within three clock edges. Pending then stays set after the input returns low.
- R7: In falling-edge mode, a 1-to-0 change sets the sticky pending flag. A 0-to-1 change does not set it.
- R8: A write to address 2 clears the pending flag of an edge-mode source when its bit is one. The bits are: source 0 bit 17, source 1 bit 20, source 2 bit 21, source 3 bit 22, source 4 bit 23, source 5 bit 24. Pending drops at the edge that takes the write.
- R9: Ones written to bits [16:0], [19:18] and [31:25] of address 2 leave every pending output unchanged.
- R10: A clear write has no effect on a source in a level mode.
- R11: When an edge is detected in the same cycle as a clear write for that source, pending stays set.
- R12: A mode write that changes a source's field clears that source's pending flag. A write of the same field value leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | 6 | Unsynchronized request lines, sources 0 to 5 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mode register A, 1 mode register B, 2 clear register |
| wr_data | input | 32 | Write data |
| irq_pend | output | 6 | Conditioned pending line per source |

## Verification
The per-source assertions run on every cycle. They cover:
- the sticky flag stays set with no clear and no mode change;
- a clear with no coincident edge drops the flag;
- an edge always sets it, even when it coincides with a clear;
- a mode change leaves it empty;
- the flag is never held in a level mode.

Other properties involve whole register writes and timing from the pins, so only the bench's scenarios show them:
- the packing of the mode fields across the two registers;
- the sparse clear bit positions;
- that reserved clear bits are ignored;
- the synchronizer latency.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  localparam int NSRC = 6;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_mode_e;

  localparam logic [1:0] ADDR_MODE_A = 2'd0;
  localparam logic [1:0] ADDR_MODE_B = 2'd1;
  localparam logic [1:0] ADDR_CLEAR  = 2'd2;

  localparam int SRCS_IN_A = 4;

  function automatic int clr_pos(input int src);
    case (src)
      0:       clr_pos = 17;
      1:       clr_pos = 20;
      2:       clr_pos = 21;
      3:       clr_pos = 22;
      4:       clr_pos = 23;
      default: clr_pos = 24;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_trig_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output trig_mode_e        mode_o [NSRC],
  output logic [NSRC-1:0]   clr_o,
  output logic [NSRC-1:0]   chg_o
);
  trig_mode_e mode_q [NSRC];
  trig_mode_e mode_d [NSRC];

  for (genvar i = 0; i < NSRC; i++) begin : g_field
    localparam logic [ADDR_W-1:0] SEL = (i < SRCS_IN_A) ? ADDR_W'(ADDR_MODE_A)
                                                          : ADDR_W'(ADDR_MODE_B);
    localparam int OFS = (i < SRCS_IN_A) ? MODE_W * i : MODE_W * (i - SRCS_IN_A);
    localparam int CPOS = clr_pos(i);

    logic field_we;
    assign field_we = wr_en && (wr_addr == SEL);

    always_comb begin
      mode_d[i] = mode_q[i];
      if (field_we) mode_d[i] = trig_mode_e'(wr_data[OFS +: MODE_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q[i] <= TRIG_HIGH;
      else if (field_we) mode_q[i] <= mode_d[i];
    end

    assign chg_o[i]  = (mode_d[i] != mode_q[i]);
    assign clr_o[i]  = wr_en && (wr_addr == ADDR_W'(ADDR_CLEAR)) && wr_data[CPOS];
    assign mode_o[i] = mode_q[i];
  end
endmodule

// File: rtl/irq_trig_cell.sv
module irq_trig_cell
  import irq_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode_i,
  input  logic       smp_i,
  input  logic       clr_i,
  input  logic       chg_i,
  output logic       pend_o
);
  logic prev_q;
  logic pend_q, pend_d;
  logic edge_hit;
  logic is_edge;

  assign is_edge = mode_i[1];

  always_comb begin
    case (mode_i)
      TRIG_RISE: edge_hit = smp_i & ~prev_q;
      TRIG_FALL: edge_hit = ~smp_i & prev_q;
      default:   edge_hit = 1'b0;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (chg_i)          pend_d = 1'b0;
    else if (edge_hit)  pend_d = 1'b1;
    else if (clr_i)     pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= smp_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = is_edge ? pend_q : (smp_i ^ mode_i[0]);

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_i && !chg_i) |=> pend_q);

  // R8
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !chg_i && !edge_hit) |=> !pend_q);

  // R11
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && !chg_i) |=> pend_q);

  // R12
  mode_change_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_i |=> !pend_q);

  // R10
  level_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_edge |-> !pend_q);
endmodule

// File: rtl/irq_trigger_unit.sv
module irq_trigger_unit
  import irq_trig_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_raw,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NSRC-1:0]   irq_pend
);
  logic [NSRC-1:0] smp;
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] chg;
  trig_mode_e      mode [NSRC];

  irq_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(irq_raw), .q_o(smp)
  );

  irq_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_o(mode), .clr_o(clr), .chg_o(chg)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_cell
    irq_trig_cell u_cell (
      .clk(clk), .rst_n(rst_n), .mode_i(mode[i]), .smp_i(smp[i]),
      .clr_i(clr[i]), .chg_i(chg[i]), .pend_o(irq_pend[i])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (irq_pend == '0) || !rst_n || $past(!rst_n) == 1'b0);
endmodule

// File: tb/irq_trigger_unit_test.sv
`timescale 1ns/1ps
module irq_trigger_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  irq_raw;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [5:0]  irq_pend;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_trigger_unit uut (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_pend(irq_pend)
  );

  localparam logic [31:0] CLR_ALL = (32'h1 << 17) | (32'h1 << 20) | (32'h1 << 21)
                                  | (32'h1 << 22) | (32'h1 << 23) | (32'h1 << 24);
  localparam int CPOS [6] = '{17, 20, 21, 22, 23, 24};

  // {src[2:0], mode[1:0], start, end, expected}
  localparam int NVEC = 13;
  localparam logic [7:0] VEC [NVEC] = '{
    {3'd0, 2'b00, 1'b0, 1'b1, 1'b1},
    {3'd1, 2'b01, 1'b1, 1'b0, 1'b1},
    {3'd2, 2'b01, 1'b0, 1'b1, 1'b0},
    {3'd3, 2'b10, 1'b0, 1'b1, 1'b1},
    {3'd4, 2'b10, 1'b1, 1'b0, 1'b0},
    {3'd5, 2'b11, 1'b1, 1'b0, 1'b1},
    {3'd0, 2'b11, 1'b0, 1'b1, 1'b0},
    {3'd1, 2'b10, 1'b0, 1'b1, 1'b1},
    {3'd2, 2'b11, 1'b1, 1'b0, 1'b1},
    {3'd3, 2'b00, 1'b1, 1'b0, 1'b0},
    {3'd4, 2'b11, 1'b1, 1'b0, 1'b1},
    {3'd5, 2'b01, 1'b0, 1'b1, 1'b0},
    {3'd5, 2'b10, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_pend actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; irq_raw = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    idle(3);
    chk("R1 during reset", irq_pend, 6'h00);
    rst_n = 1'b1;
    idle(4);
    chk("R1 after reset", irq_pend, 6'h00);

    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] src;
      logic [1:0] md;
      logic st, en, ex;
      string tag;
      {src, md, st, en, ex} = VEC[v];
      irq_raw = '0;
      wr(2'd0, 32'h0); wr(2'd1, 32'h0); wr(2'd2, CLR_ALL);
      idle(4);
      irq_raw[src] = st;
      idle(4);
      if (src < 4) wr(2'd0, 32'(md) << (2 * src));
      else         wr(2'd1, 32'(md) << (2 * (src - 4)));
      idle(4);
      irq_raw[src] = en;
      idle(4);
      case (md)
        2'b00: tag = "R4";
        2'b01: tag = "R5";
        2'b10: tag = "R6";
        default: tag = "R7";
      endcase
      tag = $sformatf("%s %s vec %0d", tag, (src < 4) ? "R2" : "R3", v);
      chk(tag, irq_pend, 6'(ex) << src);
    end

    // all sources rising edge
    irq_raw = '0;
    wr(2'd0, 32'h0); wr(2'd1, 32'h0);
    wr(2'd0, 32'hAA); wr(2'd1, 32'hA);
    idle(4);
    chk("R6 no edge yet", irq_pend, 6'h00);
    irq_raw = 6'h3F;
    idle(4);
    chk("R6 all rising", irq_pend, 6'h3F);
    irq_raw = 6'h00;
    idle(4);
    chk("R6 sticky after input low", irq_pend, 6'h3F);

    wr(2'd2, ~CLR_ALL);
    idle(2);
    chk("R9 reserved clear bits", irq_pend, 6'h3F);

    for (int i = 0; i < 6; i++) begin
      wr(2'd2, 32'h1 << CPOS[i]);
      chk($sformatf("R8 clear source %0d", i), irq_pend, 6'h3F & ~6'((2 << i) - 1));
    end

    irq_raw = 6'h3F;
    idle(4);
    chk("R6 re-arm", irq_pend, 6'h3F);
    wr(2'd0, 32'hAA);
    idle(2);
    chk("R12 same mode keeps flag", irq_pend, 6'h3F);
    wr(2'd0, 32'hFF);
    idle(2);
    chk("R12 mode change clears", irq_pend, 6'h30);

    // R11: new edge on source 4 coincides with its clear
    irq_raw[4] = 1'b0;
    idle(4);
    chk("R11 setup", irq_pend & 6'h10, 6'h10);
    @(negedge clk); irq_raw[4] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h1 << 23;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    chk("R11 edge wins over clear", irq_pend & 6'h10, 6'h10);
    wr(2'd2, 32'h1 << 23);
    chk("R8 later clear of source 4", irq_pend & 6'h10, 6'h00);

    // R10: level mode ignores clear
    wr(2'd1, 32'h0);
    idle(4);
    chk("R10 level source 5 high", irq_pend & 6'h20, 6'h20);
    wr(2'd2, CLR_ALL);
    idle(1);
    chk("R10 clear ignored in level mode", irq_pend & 6'h30, 6'h30);

    done = 1'b1;
    finish_run();
  end
endmodule